// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Core

This block is the control front end of a clocked burst memory with a 36-bit word made of four 9-bit byte lanes, together with the small storage array it drives. On every rising clock edge it samples an address, three chip selects, two address strobes, a step input, a burst-order select, the write controls and the write data. A strobe loads a base address. Subsequent cycles without a strobe continue the burst: a 2-bit beat counter replaces the two lowest address bits and either advances or holds. The counter can walk the four words in linear order or in interleaved order.

One strobe is meant for a processor and always starts a read. It only counts when the first chip select is active. The other strobe is meant for a cache controller and starts a read or a write, depending on the write controls. A global-write input overrides the per-lane write controls. Read data appears one clock after the access, together with a valid flag. The tri-state data bus is modelled as a drive flag, gated without a clock by an active-low output enable. A sleep input freezes the block.

Top module: `burst_sram_ctl`

## Requirements
- R1: While `rst_n` is low, `rvalid_o` and `drive_o` are low after the next clock edge.
- R2: A processor strobe (`strb_proc_n_i` low) with `ce1_n_i` low and the device selected loads `addr_i` and reads that word. The read is always a read, even when the write inputs are active. `rdata_o` holds the word and `rvalid_o` is high after that edge.
- R3: The device is selected only when `ce1_n_i`=0, `ce2_i`=1 and `ce3_n_i`=0. A controller strobe (`strb_ctrl_n_i` low) loads `addr_i` and makes a read or a write according to R9/R10. When the controller strobe finds the device not selected, the block is deselected: it makes no access (`rvalid_o` low) until the next strobe.
- R4: A processor strobe is ignored while `ce1_n_i` is high. Such a cycle behaves as a burst-continue cycle.
- R5: When both strobes are low and the processor strobe qualifies, the processor strobe wins. The cycle is a read and nothing is written.
- R6: In a continue cycle, `step_n_i`=0 advances the beat counter by one before the access. `step_n_i`=1 is a wait cycle that accesses the same word again.
- R7: With `burst_mode_i`=0 (linear), the low two address bits of beat n are (start + n) mod 4. The upper bits keep the loaded value.
- R8: With `burst_mode_i`=1 (interleaved), the low two address bits of beat n are start XOR n.
- R9: `all_wr_n_i`=0 in a write-capable cycle writes all 36 bits, whatever `lane_wr_n_i` and `lane_sel_n_i` are. A write cycle leaves `rvalid_o` low.
- R10: With `all_wr_n_i`=1 and `lane_wr_n_i`=0, each bit i of `lane_sel_n_i` that is 0 writes lane i (data bits 9i+8..9i). With `lane_wr_n_i`=1 the cycle is a read, whatever `lane_sel_n_i` is.
- R11: `drive_o` is high exactly when `rvalid_o` is high, `oe_n_i` is low and `sleep_i` is low. It follows `oe_n_i` without waiting for a clock.
- R12: While `sleep_i` is high, all other inputs are ignored. The memory, the burst state, `rdata_o` and `rvalid_o` hold their values, and `drive_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | Word address |
| ce1_n_i | input | 1 | Chip select 1, active low; also qualifies processor strobe |
| ce2_i | input | 1 | Chip select 2, active high |
| ce3_n_i | input | 1 | Chip select 3, active low |
| strb_proc_n_i | input | 1 | Processor address strobe, active low |
| strb_ctrl_n_i | input | 1 | Controller address strobe, active low |
| step_n_i | input | 1 | Burst advance, active low; high is a wait cycle |
| burst_mode_i | input | 1 | 0 linear order, 1 interleaved order |
| all_wr_n_i | input | 1 | Global write of all lanes, active low |
| lane_wr_n_i | input | 1 | Per-lane write enable, active low |
| lane_sel_n_i | input | LANES | Per-lane write select, active low |
| wdata_i | input | LANES*LANE_W | Write data |
| oe_n_i | input | 1 | Output enable, active low, unclocked |
| sleep_i | input | 1 | Standby, active high |
| rdata_o | output | LANES*LANE_W | Read data |
| rvalid_o | output | 1 | Read data valid |
| drive_o | output | 1 | Data bus would be driven |

## Verification
Four distinct words are written, and bursts are then started from a middle offset in both orders. A wrong stepping rule therefore returns a different, recognisable word on each beat, and the linear wrap (3 to 0) is told apart from the interleaved XOR pattern. Wait cycles, where the step input is inactive, separate holding the counter from advancing it. Byte-lane writes with a mixed select pattern expose lane-to-bit mapping errors. A global write with every lane deselected shows whether the override works. Directed patterns give both strobes at once, a processor strobe with the first select inactive, deselection and sleep; each is chosen so that the wrong interpretation would return a different word or a valid flag.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int CNT_W = 2;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } burst_order_e;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } access_e;

endpackage

// File: rtl/burst_index_gen.sv
module burst_index_gen
    import burst_sram_pkg::*;
#(
    parameter int IDX_W = CNT_W
) (
    input  logic [IDX_W-1:0] start_i,
    input  logic [IDX_W-1:0] beat_i,
    input  burst_order_e     order_i,
    output logic [IDX_W-1:0] idx_o
);

    // Linear order wraps modulo 2**IDX_W; interleaved order flips start bits.
    always_comb begin
        if (order_i == ORDER_INTERLEAVED) begin
            idx_o = start_i ^ beat_i;
        end else begin
            idx_o = start_i + beat_i;
        end
    end

endmodule

// File: rtl/lane_wen_decode.sv
module lane_wen_decode #(
    parameter int LANES = 4
) (
    input  logic             all_wr_n_i,
    input  logic             lane_wr_n_i,
    input  logic [LANES-1:0] lane_sel_n_i,
    output logic [LANES-1:0] wen_o
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Global write overrides every per-lane control.
        assign wen_o[l] = !all_wr_n_i || (!lane_wr_n_i && !lane_sel_n_i[l]);
    end

endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANES-1:0]  wen_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (wen_i[l]) begin
                mem[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
            end
            if (rd_en_i) begin
                rd_q <= mem[addr_i];
            end
        end

        assign rdata_o[l*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W,
    localparam int BASE_W = ADDR_W - CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ce1_n_i,
    input  logic              ce2_i,
    input  logic              ce3_n_i,
    input  logic              strb_proc_n_i,
    input  logic              strb_ctrl_n_i,
    input  logic              step_n_i,
    input  logic              burst_mode_i,
    input  logic              all_wr_n_i,
    input  logic              lane_wr_n_i,
    input  logic [LANES-1:0]  lane_sel_n_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              oe_n_i,
    input  logic              sleep_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic              drive_o
);

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [CNT_W-1:0]  start_lo;
        logic [CNT_W-1:0]  beat;
        logic              active;
        logic              rvalid;
    } ctl_state_t;

    ctl_state_t   st_d, st_q;
    access_e      acc_kind;
    burst_order_e order;
    logic         selected;
    logic         proc_win;
    logic         load;
    logic [LANES-1:0]  lane_wen;
    logic [LANES-1:0]  arr_wen;
    logic [CNT_W-1:0]  acc_lo;
    logic [ADDR_W-1:0] acc_addr;

    assign order    = burst_order_e'(burst_mode_i);
    assign selected = !ce1_n_i && ce2_i && !ce3_n_i;
    assign proc_win = !strb_proc_n_i && !ce1_n_i;
    assign load     = proc_win || !strb_ctrl_n_i;

    lane_wen_decode #(
        .LANES (LANES)
    ) i_wen (
        .all_wr_n_i   (all_wr_n_i),
        .lane_wr_n_i  (lane_wr_n_i),
        .lane_sel_n_i (lane_sel_n_i),
        .wen_o        (lane_wen)
    );

    // Next-state process: every register value is computed here.
    always_comb begin
        st_d     = st_q;
        acc_kind = ACC_NONE;
        if (!sleep_i) begin
            if (load) begin
                st_d.base     = addr_i[ADDR_W-1:CNT_W];
                st_d.start_lo = addr_i[CNT_W-1:0];
                st_d.beat     = '0;
                st_d.active   = selected;
                if (selected) begin
                    if (proc_win || (lane_wen == '0)) begin
                        acc_kind = ACC_READ;
                    end else begin
                        acc_kind = ACC_WRITE;
                    end
                end
            end else if (st_q.active) begin
                if (!step_n_i) begin
                    st_d.beat = st_q.beat + 1'b1;
                end
                acc_kind = (lane_wen == '0) ? ACC_READ : ACC_WRITE;
            end
            st_d.rvalid = (acc_kind == ACC_READ);
        end
    end

    burst_index_gen #(
        .IDX_W (CNT_W)
    ) i_idx (
        .start_i (st_d.start_lo),
        .beat_i  (st_d.beat),
        .order_i (order),
        .idx_o   (acc_lo)
    );

    assign acc_addr = {st_d.base, acc_lo};
    assign arr_wen  = (acc_kind == ACC_WRITE) ? lane_wen : '0;

    sram_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) i_array (
        .clk     (clk),
        .addr_i  (acc_addr),
        .wen_i   (arr_wen),
        .rd_en_i (acc_kind == ACC_READ),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o)
    );

    // Register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rvalid_o = st_q.rvalid;
    assign drive_o  = st_q.rvalid && !oe_n_i && !sleep_i;

endmodule

// File: rtl/burst_sram_ctl_chk.sv
module burst_sram_ctl_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_i,
    input logic              strb_proc_n_i,
    input logic              strb_ctrl_n_i,
    input logic              ce1_n_i,
    input logic              ce2_i,
    input logic              ce3_n_i,
    input logic              all_wr_n_i,
    input logic              oe_n_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              rvalid_o,
    input logic              drive_o
);

    logic sel_ok;
    assign sel_ok = !ce1_n_i && ce2_i && !ce3_n_i;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!rvalid_o && !drive_o));

    assert_proc_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && !strb_proc_n_i && sel_ok) |=> rvalid_o);

    assert_deselect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && (strb_proc_n_i || ce1_n_i) && !strb_ctrl_n_i && !sel_ok) |=> !rvalid_o);

    assert_global_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && strb_proc_n_i && !strb_ctrl_n_i && sel_ok && !all_wr_n_i) |=> !rvalid_o);

    assert_oe_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> !drive_o);

    assert_sleep_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |-> !drive_o);

    assert_sleep_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> ($stable(rvalid_o) && $stable(rdata_o)));

endmodule

bind burst_sram_ctl burst_sram_ctl_chk #(
    .DATA_W (DATA_W)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_i       (sleep_i),
    .strb_proc_n_i (strb_proc_n_i),
    .strb_ctrl_n_i (strb_ctrl_n_i),
    .ce1_n_i       (ce1_n_i),
    .ce2_i         (ce2_i),
    .ce3_n_i       (ce3_n_i),
    .all_wr_n_i    (all_wr_n_i),
    .oe_n_i        (oe_n_i),
    .rdata_o       (rdata_o),
    .rvalid_o      (rvalid_o),
    .drive_o       (drive_o)
);

// File: tb/test_burst_sram_ctl.sv
`timescale 1ns/1ps
module test_burst_sram_ctl;

    localparam int ADDR_W = 8;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DW     = LANES * LANE_W;

    localparam logic [DW-1:0] D0 = 36'h123456789;
    localparam logic [DW-1:0] D1 = 36'h9ABCDEF01;
    localparam logic [DW-1:0] D2 = 36'h000000000;
    localparam logic [DW-1:0] D3 = 36'hFEDCBA987;
    localparam logic [DW-1:0] ONES = 36'hFFFFFFFFF;
    localparam logic [DW-1:0] FIVES = 36'h555555555;
    // D2 with lanes 0 (bits 8..0) and 2 (bits 26..18) overwritten by ones.
    localparam logic [DW-1:0] MERGED = 36'h007FC01FF;

    typedef struct packed {
        logic          proc_n;
        logic          ctrl_n;
        logic          step_n;
        logic          mode;
        logic          all_n;
        logic          lane_n;
        logic [3:0]    sel_n;
        logic [7:0]    addr;
        logic [DW-1:0] wdata;
        logic          exp_v;
        logic [DW-1:0] exp_d;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,4'hF,8'h10,D0,   1'b0,D2,    8'd9},  // R9 load write
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,4'hF,8'hEE,D1,   1'b0,D2,    8'd6},  // R6 step write 0x11
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,4'hF,8'hEE,D2,   1'b0,D2,    8'd6},  // 0x12
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,4'hF,8'hEE,D3,   1'b0,D2,    8'd6},  // 0x13
        '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,8'h12,D0,   1'b1,D2,    8'd2},  // R2 read 0x12
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,8'h00,D0,   1'b1,D3,    8'd7},  // R7 0x13
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,8'h00,D0,   1'b1,D0,    8'd7},  // R7 wrap 0x10
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,8'h00,D0,   1'b1,D0,    8'd6},  // R6 wait
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,8'h00,D0,   1'b1,D1,    8'd7},  // R7 0x11
        '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,8'h11,D0,   1'b1,D1,    8'd2},  // R2 read 0x11
        '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,8'h00,D0,   1'b1,D0,    8'd8},  // R8 1^1=0
        '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,8'h00,D0,   1'b1,D3,    8'd8},  // R8 1^2=3
        '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,8'h00,D0,   1'b1,D2,    8'd8},  // R8 1^3=2
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,4'hA,8'h12,ONES, 1'b0,D2,    8'd10}, // R10 lanes 0,2
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,4'hF,8'h12,D0,   1'b1,MERGED,8'd10}, // R10 readback
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'hF,8'h13,FIVES,1'b0,D2,    8'd9},  // R9 override
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,4'hF,8'h13,D0,   1'b1,FIVES, 8'd9},  // R9 readback
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,4'h0,8'h10,ONES, 1'b1,D0,    8'd10}  // R10 read, no write
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
    logic              proc_n = 1'b1, ctrl_n = 1'b1, step_n = 1'b1, mode = 1'b0;
    logic              all_n = 1'b1, lane_n = 1'b1;
    logic [LANES-1:0]  sel_n = '1;
    logic [DW-1:0]     wdata = '0;
    logic              oe_n = 1'b0, sleep = 1'b0;
    logic [DW-1:0]     rdata;
    logic              rvalid, drive;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_sram_ctl #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) i_burst_sram_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr_i        (addr),
        .ce1_n_i       (ce1_n),
        .ce2_i         (ce2),
        .ce3_n_i       (ce3_n),
        .strb_proc_n_i (proc_n),
        .strb_ctrl_n_i (ctrl_n),
        .step_n_i      (step_n),
        .burst_mode_i  (mode),
        .all_wr_n_i    (all_n),
        .lane_wr_n_i   (lane_n),
        .lane_sel_n_i  (sel_n),
        .wdata_i       (wdata),
        .oe_n_i        (oe_n),
        .sleep_i       (sleep),
        .rdata_o       (rdata),
        .rvalid_o      (rvalid),
        .drive_o       (drive)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        proc_n = 1'b1; ctrl_n = 1'b1; step_n = 1'b1;
        all_n = 1'b1; lane_n = 1'b1; sel_n = '1;
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0; sleep = 1'b0; oe_n = 1'b0;
    endtask

    // Inputs change at the falling edge; the rising edge takes them in,
    // and results are sampled at the following falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rvalid == 1'b0, "R1 rvalid", {35'd0, rvalid}, '0);
        check(drive == 1'b0, "R1 drive", {35'd0, drive}, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            proc_n = TBL[i].proc_n; ctrl_n = TBL[i].ctrl_n; step_n = TBL[i].step_n;
            mode = TBL[i].mode; all_n = TBL[i].all_n; lane_n = TBL[i].lane_n;
            sel_n = TBL[i].sel_n; addr = TBL[i].addr; wdata = TBL[i].wdata;
            tick();
            check(rvalid == TBL[i].exp_v, $sformatf("R%0d valid row %0d", TBL[i].req, i),
                  {35'd0, rvalid}, {35'd0, TBL[i].exp_v});
            if (TBL[i].exp_v) begin
                check(rdata == TBL[i].exp_d, $sformatf("R%0d data row %0d", TBL[i].req, i),
                      rdata, TBL[i].exp_d);
            end
        end
        idle();
        mode = 1'b0;

        // R4: processor strobe with ce1 high is a continue (wait) at 0x10.
        proc_n = 1'b0; ce1_n = 1'b1; addr = 8'h13;
        tick();
        check(rvalid && rdata == D0, "R4 ignored strobe", rdata, D0);
        idle();

        // R5: both strobes, write inputs active: read wins, no write.
        proc_n = 1'b0; ctrl_n = 1'b0; all_n = 1'b0; wdata = ONES; addr = 8'h11;
        tick();
        check(rvalid && rdata == D1, "R5 proc priority", rdata, D1);
        idle();
        ctrl_n = 1'b0; addr = 8'h11;
        tick();
        check(rvalid && rdata == D1, "R5 no write", rdata, D1);
        idle();

        // R3: controller strobe with ce2 low deselects; continue makes no access.
        ctrl_n = 1'b0; ce2 = 1'b0; addr = 8'h12;
        tick();
        check(!rvalid, "R3 deselect", {35'd0, rvalid}, '0);
        idle();
        step_n = 1'b0;
        tick();
        check(!rvalid, "R3 stay deselected", {35'd0, rvalid}, '0);
        idle();

        // R12: sleep holds state and blocks a write.
        proc_n = 1'b0; addr = 8'h13;
        tick();
        check(rvalid && rdata == FIVES, "R12 pre-sleep read", rdata, FIVES);
        idle();
        sleep = 1'b1; ctrl_n = 1'b0; all_n = 1'b0; wdata = '0; addr = 8'h13;
        tick();
        check(rvalid && rdata == FIVES, "R12 hold", rdata, FIVES);
        check(!drive, "R12 drive off", {35'd0, drive}, '0);
        idle();
        #1;
        // R11 drive follows rvalid once sleep drops
        check(drive, "R11 drive on", {35'd0, drive}, 36'd1);
        ctrl_n = 1'b0; addr = 8'h13;
        tick();
        check(rvalid && rdata == FIVES, "R12 memory kept", rdata, FIVES);
        // R11 unclocked output-enable gate
        oe_n = 1'b1;
        #1;
        check(!drive, "R11 oe off", {35'd0, drive}, '0);
        oe_n = 1'b0;
        #1;
        check(drive, "R11 oe on", {35'd0, drive}, 36'd1);
        idle();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule